// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter with Byte Access

This block is a 16-bit up-counter peripheral that sits on an 8-bit register bus. It counts either an internal instruction-rate tick (the system clock divided by four) or rising edges of an external clock input. A two-bit prescaler field divides whichever tick is selected by 1, 2, 4 or 8 before it reaches the counter.

External edges can take a fully synchronized path, with two flops, an edge register and then the counter. They can also take a fast path that skips the synchronizer pair. When the count rolls over, a sticky overflow flag is raised and driven out as an interrupt request. An enabled compare-event input clears the count.

Software reads and writes the 16-bit count one byte at a time. A high-byte buffer keeps the two halves coherent. Reading the low byte captures the live high byte into the buffer. Writing the high byte only fills the buffer, and writing the low byte loads the buffer and the new low byte into the count in one step.

Top module: `tmr16_periph`

## Requirements
- R1: After reset the count, the control byte, the overflow flag and the read data are all zero.
- R2: With control bit 1 (source) at 0 and control bit 0 (run) at 1, the count gains one for every 4 system clock cycles times the prescale divisor.
- R3: Control bits 4:3 select the prescale divisor: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8 selected ticks per count.
- R4: With the source bit at 1, rising edges of the external clock are counted. With control bit 2 at 0 (synchronized), the count changes on the third system clock edge after the input rises. With control bit 2 at 1 (fast path), it changes on the second.
- R5: While the run bit is 0, the count does not advance on any tick.
- R6: A count step from 0xFFFF to 0x0000 sets the overflow flag. The flag reads as control bit 7 and drives the interrupt output. It stays set until a control write with bit 7 at 0 clears it, and a control write with bit 7 at 1 has no effect on it. When an overflow and a clearing write fall in the same cycle, the flag ends up set.
- R7: When control bit 5 (trigger enable) is 1, a high cycle on the compare trigger input clears the count at the next clock edge. When bit 5 is 0, the trigger is ignored.
- R8: Address 0 reads the live low byte, and that read captures the live high byte into the buffer. Address 1 reads the buffer, and address 2 reads the control byte.
- R9: A write to address 1 changes only the buffer. A write to address 0 loads the count with the buffer as its high byte and the written data as its low byte.
- R10: The prescaler's partial progress is discarded whenever a count byte is written or a control write changes the prescale field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 low count, 1 high buffer, 2 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when no read |
| ext_clk | input | 1 | External count clock |
| cmp_trig | input | 1 | Compare-event clear request |
| ovf_irq | output | 1 | Sticky overflow interrupt request |

## Verification
The bench sweeps every prescale setting in timer mode and checks the exact count gained over whole periods. A wrong divisor decode or a dropped tick would show up as a wrong increment. It measures the one-cycle difference between the synchronized and fast external paths, so a swapped path select is caught. It lands a flag clear in the same cycle as a rollover, so a design that gives the clear priority would lose the interrupt. It also checks that a partial prescale count is discarded on count writes and on prescale changes, and that a high-byte read returns the value captured at the low-byte read even after the live count has moved.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W   = 8;
    localparam int PS_W     = 2;
    localparam int PCNT_W   = (1 << PS_W) - 1;
    localparam int TICK_DIV = 4;

    typedef enum logic [1:0] {
        REG_LO   = 2'd0,
        REG_HI   = 2'd1,
        REG_CTL  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // Stored control fields; bit 7 (flag) and bit 6 (reserved) live elsewhere.
    typedef struct packed {
        logic            trig_en;
        logic [PS_W-1:0] psel;
        logic            fast_ext;
        logic            src_ext;
        logic            run;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic [PCNT_W-1:0] ps_last(input logic [PS_W-1:0] sel);
        logic [PCNT_W-1:0] one;
        one = PCNT_W'(1);
        return (one << sel) - one;
    endfunction

endpackage

// File: rtl/tmr_tick_src.sv
module tmr_tick_src
    import tmr_pkg::*;
#(
    parameter int INT_DIV = TICK_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk,
    input  logic src_ext,
    input  logic fast_ext,
    output logic tick
);
    localparam int DIV_W = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;

    logic [DIV_W-1:0] div_q;
    logic             int_tick;
    logic [2:0]       sync_q;
    logic [1:0]       fast_q;
    logic             sync_edge;
    logic             fast_edge;

    // Free-running instruction-rate divider
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (div_q == DIV_W'(INT_DIV - 1)) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    assign int_tick = (div_q == DIV_W'(INT_DIV - 1));

    // Synchronized path: two flops, then an edge register
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            fast_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], ext_clk};
            fast_q <= {fast_q[0], ext_clk};
        end
    end

    assign sync_edge = sync_q[1] & ~sync_q[2];
    assign fast_edge = fast_q[0] & ~fast_q[1];

    always_comb begin
        if (!src_ext) begin
            tick = int_tick;
        end else if (fast_ext) begin
            tick = fast_edge;
        end else begin
            tick = sync_edge;
        end
    end

    // R2: internal ticks are isolated single-cycle strobes
    a_r2_int_tick_gap: assert property (@(posedge clk) disable iff (rst)
        int_tick |=> !int_tick);

    // R4: a synchronized edge is preceded by a fast-path edge one cycle earlier
    a_r4_sync_follows_fast: assert property (@(posedge clk) disable iff (rst)
        fast_edge |=> sync_edge);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            en,
    input  logic [PS_W-1:0] psel,
    output logic            fire
);
    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W-1:0] last;

    assign last = ps_last(psel);
    assign fire = en && (pcnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcnt_q <= '0;
        end else if (en) begin
            if (pcnt_q == last) begin
                pcnt_q <= '0;
            end else begin
                pcnt_q <= pcnt_q + PCNT_W'(1);
            end
        end
    end

    // R10: the partial count never exceeds the current divisor's range
    a_r10_pcnt_in_range: assert property (@(posedge clk) disable iff (rst)
        pcnt_q <= last);

    // R10: a clear empties the prescaler
    a_r10_clr_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pcnt_q == '0));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              rd_lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              trig_hit,
    input  logic              inc,
    input  logic              ovf_clr,
    output logic [2*BYTE_W-1:0] cnt,
    output logic [BYTE_W-1:0] hi_buf,
    output logic              ovf
);
    localparam int CNT_W = 2 * BYTE_W;

    logic wrap;

    assign wrap = inc && !wr_lo && !trig_hit && (cnt == {CNT_W{1'b1}});

    // Priority: byte load, then trigger clear, then increment
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr_lo) begin
            cnt <= {hi_buf, wdata};
        end else if (trig_hit) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_buf <= '0;
        end else if (wr_hi) begin
            hi_buf <= wdata;
        end else if (rd_lo) begin
            hi_buf <= cnt[CNT_W-1 -: BYTE_W];
        end
    end

    // Rollover wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
        end else if (wrap) begin
            ovf <= 1'b1;
        end else if (ovf_clr) begin
            ovf <= 1'b0;
        end
    end

    a_r6_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);

    a_r7_trig_zeroes: assert property (@(posedge clk) disable iff (rst)
        (trig_hit && !wr_lo) |=> (cnt == '0));

    a_r8_read_captures_high: assert property (@(posedge clk) disable iff (rst)
        (rd_lo && !wr_hi) |=> (hi_buf == $past(cnt[CNT_W-1 -: BYTE_W])));

endmodule

// File: rtl/tmr16_periph.sv
module tmr16_periph
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_clk,
    input  logic              cmp_trig,
    output logic              ovf_irq
);
    localparam int CNT_W = 2 * BYTE_W;

    reg_sel_e          sel;
    ctl_t              ctl_q;
    ctl_t              ctl_wr;
    logic              wr_lo, wr_hi, wr_ctl, rd_lo;
    logic              presc_clr;
    logic              trig_hit;
    logic              tick;
    logic              fire;
    logic              ovf;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] hi_buf;

    assign sel    = reg_sel_e'(bus_addr);
    assign wr_lo  = bus_wr && (sel == REG_LO);
    assign wr_hi  = bus_wr && (sel == REG_HI);
    assign wr_ctl = bus_wr && (sel == REG_CTL);
    assign rd_lo  = bus_rd && (sel == REG_LO);
    assign ctl_wr = ctl_t'(bus_wdata[CTL_W-1:0]);

    assign presc_clr = wr_lo || wr_hi || (wr_ctl && (ctl_wr.psel != ctl_q.psel));
    assign trig_hit  = cmp_trig && ctl_q.trig_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_ctl) begin
            ctl_q <= ctl_wr;
        end
    end

    tmr_tick_src #(.INT_DIV(TICK_DIV)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .ext_clk  (ext_clk),
        .src_ext  (ctl_q.src_ext),
        .fast_ext (ctl_q.fast_ext),
        .tick     (tick)
    );

    tmr_prescaler u_presc (
        .clk  (clk),
        .rst  (rst),
        .clr  (presc_clr),
        .en   (tick && ctl_q.run),
        .psel (ctl_q.psel),
        .fire (fire)
    );

    tmr_count_core u_core (
        .clk      (clk),
        .rst      (rst),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .rd_lo    (rd_lo),
        .wdata    (bus_wdata),
        .trig_hit (trig_hit),
        .inc      (fire),
        .ovf_clr  (wr_ctl && !bus_wdata[BYTE_W-1]),
        .cnt      (cnt),
        .hi_buf   (hi_buf),
        .ovf      (ovf)
    );

    assign ovf_irq = ovf;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                REG_LO:   bus_rdata = cnt[BYTE_W-1:0];
                REG_HI:   bus_rdata = hi_buf;
                REG_CTL:  bus_rdata = {ovf, 1'b0, ctl_q};
                REG_NONE: bus_rdata = '0;
            endcase
        end
    end

    // R5: with run off and no load or trigger, the count holds
    a_r5_run_off_holds: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.run && !wr_lo && !trig_hit) |=> (cnt == $past(cnt)));

    // R7: a trigger with the enable clear leaves the count alone unless ticks arrive
    a_r7_trig_masked: assert property (@(posedge clk) disable iff (rst)
        (cmp_trig && !ctl_q.trig_en && !fire && !wr_lo) |=> (cnt == $past(cnt)));

    // R9: a high-byte write never disturbs the live count
    a_r9_hi_write_count_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && !fire && !trig_hit) |=> (cnt == $past(cnt)));

endmodule

// File: tb/tmr16_periph_bench.sv
`timescale 1ns/1ps
module tmr16_periph_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bus_addr;
    logic       bus_wr, bus_rd;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       ext_clk, cmp_trig;
    logic       ovf_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmr16_periph u_tmr16_periph (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk(ext_clk), .cmp_trig(cmp_trig), .ovf_irq(ovf_irq)
    );

    localparam logic [7:0] C_RUN = 8'h01, C_EXT = 8'h02, C_FAST = 8'h04, C_TEN = 8'h20;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read16(output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_read(2'd0, lo);
        bus_read(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic write16(input logic [15:0] v);
        bus_write(2'd1, v[15:8]);
        bus_write(2'd0, v[7:0]);
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1;
            repeat (4) @(negedge clk);
            ext_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic trig_pulse();
        cmp_trig = 1'b1;
        @(negedge clk);
        cmp_trig = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] a, b;
        logic [7:0]  r;
        rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
        ext_clk = 0; cmp_trig = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata idle", {8'h00, bus_rdata}, 16'h0000);
        bus_read(2'd2, r);  check("R1 control", {8'h00, r}, 16'h0000);
        read16(a);          check("R1 count", a, 16'h0000);
        check("R1 irq", {15'b0, ovf_irq}, 16'h0000);

        // R2/R3 timer mode, every prescale setting
        for (int ps = 0; ps < 4; ps++) begin
            int per;
            per = 4 * (1 << ps) * 5;
            bus_write(2'd2, C_RUN | 8'(ps << 3));
            read16(a);
            repeat (per - 2) @(negedge clk);
            read16(b);
            check($sformatf("R2 R3 timer psel=%0d delta", ps), b - a, 16'd5);
        end

        // R4 path latency, fast then synchronized
        for (int fp = 1; fp >= 0; fp--) begin
            logic [7:0] c1, c2, c3;
            bus_write(2'd2, C_RUN | C_EXT | (fp ? C_FAST : 8'h00));
            write16(16'h0000);
            repeat (4) @(negedge clk);
            ext_clk = 1'b1; bus_addr = 2'd0; bus_rd = 1'b1;
            @(negedge clk); #1 c1 = bus_rdata;
            @(negedge clk); #1 c2 = bus_rdata;
            @(negedge clk); #1 c3 = bus_rdata;
            bus_rd = 1'b0; ext_clk = 1'b0;
            repeat (4) @(negedge clk);
            check("R4 one edge after 1 clk", {8'h00, c1}, 16'h0000);
            check("R4 one edge after 2 clk", {8'h00, c2}, fp ? 16'h0001 : 16'h0000);
            check("R4 one edge after 3 clk", {8'h00, c3}, 16'h0001);
            ext_pulses(6);
            read16(a);
            check("R4 edge count", a, 16'd7);
        end

        // R5 run off
        bus_write(2'd2, C_EXT | C_FAST);
        write16(16'h0042);
        ext_pulses(3);
        read16(a); check("R5 run off holds", a, 16'h0042);

        // R6 overflow flag
        bus_write(2'd2, C_RUN | C_EXT | C_FAST);
        write16(16'hFFFE);
        ext_pulses(1);
        read16(a); check("R6 at FFFF", a, 16'hFFFF);
        bus_read(2'd2, r); check("R6 flag clear before wrap", {8'h00, r}, 16'h0007);
        ext_pulses(1);
        read16(a); check("R6 wrapped", a, 16'h0000);
        bus_read(2'd2, r); check("R6 flag set", {8'h00, r}, 16'h0087);
        check("R6 irq set", {15'b0, ovf_irq}, 16'h0001);
        bus_write(2'd2, 8'h87);
        bus_read(2'd2, r); check("R6 write one no effect", {8'h00, r}, 16'h0087);
        write16(16'hFFFF);
        repeat (4) @(negedge clk);
        ext_clk = 1'b1;
        @(negedge clk);
        bus_write(2'd2, 8'h07);
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        bus_read(2'd2, r); check("R6 wrap beats clear", {8'h00, r}, 16'h0087);
        read16(a); check("R6 wrap in clear cycle", a, 16'h0000);
        bus_write(2'd2, 8'h07);
        bus_read(2'd2, r); check("R6 clear by zero", {8'h00, r}, 16'h0007);
        check("R6 irq cleared", {15'b0, ovf_irq}, 16'h0000);

        // R7 trigger
        bus_write(2'd2, C_TEN);
        write16(16'h1234);
        trig_pulse();
        read16(a); check("R7 trigger clears", a, 16'h0000);
        bus_write(2'd2, 8'h00);
        write16(16'h1234);
        trig_pulse();
        read16(a); check("R7 trigger masked", a, 16'h1234);

        // R8 coherent read
        bus_write(2'd2, C_TEN);
        write16(16'h56AB);
        bus_read(2'd0, r); check("R8 low byte", {8'h00, r}, 16'h00AB);
        trig_pulse();
        bus_read(2'd1, r); check("R8 captured high", {8'h00, r}, 16'h0056);
        read16(a); check("R8 fresh read", a, 16'h0000);

        // R9 buffered writes
        write16(16'h1234);
        read16(a); check("R9 loaded", a, 16'h1234);
        bus_write(2'd1, 8'h77);
        bus_read(2'd1, r); check("R9 buffer holds write", {8'h00, r}, 16'h0077);
        read16(a); check("R9 count untouched by high write", a, 16'h1234);

        // R10 prescaler clears, with R3 divide-by-4 and divide-by-8
        bus_write(2'd2, C_RUN | C_EXT | C_FAST | 8'h10);
        write16(16'h0000);
        ext_pulses(3);
        read16(a); check("R3 div4 three edges", a, 16'h0000);
        bus_write(2'd0, 8'h00);
        ext_pulses(3);
        read16(a); check("R10 count write clears prescaler", a, 16'h0000);
        ext_pulses(1);
        read16(a); check("R3 R10 div4 fourth edge", a, 16'h0001);
        bus_write(2'd2, C_RUN | C_EXT | C_FAST | 8'h18);
        write16(16'h0000);
        ext_pulses(5);
        read16(a); check("R3 div8 five edges", a, 16'h0000);
        bus_write(2'd2, C_RUN | C_EXT | C_FAST | 8'h08);
        ext_pulses(2);
        read16(a); check("R10 field change clears prescaler", a, 16'h0001);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule